// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Engine

This block is the read-data path of a serial flash slave. An upstream command decoder presents a read opcode and a start address once the address bytes have arrived. The engine then decides whether a dummy byte must pass before data starts. It fetches bytes from a synchronous, byte-wide memory port ahead of need. It serialises each byte most-significant bit first onto one, two or four of the four shared I/O lanes.

The design runs on a fast system clock. Chip select (`csN`) is sampled in that domain, and the serial clock arrives as a one-cycle strobe (`sckFall`) for each falling edge of SCK. Output registers update only on such strobes, and every lane enable is forced off as soon as chip select goes high. Lane numbering throughout: lane 0 is the serial-input pin, lane 1 the serial-output pin, lane 2 the write-protect pin, lane 3 the hold pin, and `ioOut[i]`/`ioOe[i]` belong to lane i. The address counter is `ADDR_W` bits wide; by default that gives a top byte of 7FFFFh, after which the stream continues from 00000h.

Top module: `flash_read_engine`

## Requirements
- R1: Opcode 03h starts a one-lane read with no dummy clocks: data bit 7 of the start byte appears on the first `sckFall` after the command is accepted.
- R2: Opcode 0Bh starts a one-lane read preceded by 8 falling strobes during which no lane is driven; data bit 7 appears on the 9th falling strobe.
- R3: Opcode 3Bh has the same 8-strobe dummy phase, then sends 2 bits per strobe: the higher bit on lane 1, the lower on lane 0, with `ioOe` = 0011b.
- R4: Opcode 6Bh has the same 8-strobe dummy phase, then sends 4 bits per strobe: bits 7..4 (then 3..0) on lanes 3..0, with `ioOe` = 1111b.
- R5: In one-lane reads, data is driven only on lane 1 (`ioOe` = 0010b, `ioOut` = {0,0,bit,0}), MSB first. `ioOut` changes only in the cycle after an `sckFall` strobe.
- R6: Successive bytes come from successive memory addresses with no idle strobe between them; each byte is requested on `memRd`/`memAddr` before its first bit is needed.
- R7: After the byte at address 2^ADDR_W-1 (7FFFFh by default), the next byte comes from address 0 with no extra strobe.
- R8: Raising `csN` at any point, including mid-byte, drives `ioOe` to 0 in the same cycle and ends the read. Later strobes drive nothing until a new command is accepted.
- R9: `ioOe` is 0 after reset, while deselected, and throughout the opcode, address and dummy phases.
- R10: An opcode other than 03h, 0Bh, 3Bh or 6Bh is ignored, and a `cmdValid` seen while `csN` is high is ignored. In both cases no lane is driven by the strobes that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low, synchronous to `clk` |
| sckFall | input | 1 | One-cycle strobe per falling SCK edge |
| cmdValid | input | 1 | One-cycle strobe: `opcode` and `startAddr` are valid |
| opcode | input | 8 | Read opcode from the command decoder |
| startAddr | input | ADDR_W | First byte address of the read |
| memRd | output | 1 | Memory read request; data is returned one clock later |
| memAddr | output | ADDR_W | Memory read address |
| memData | input | 8 | Memory read data, valid the cycle after `memRd` |
| ioOut | output | 4 | Output value for lanes 3..0 |
| ioOe | output | 4 | Output enable for lanes 3..0 |

## Verification
The assertions take for granted that at least three clock cycles separate an accepted `cmdValid` from the first `sckFall`. They also assume that consecutive `sckFall` strobes are at least four cycles apart. This gives the one-cycle memory port time to refill the prefetch buffer, and it keeps memory requests single-cycle pulses. The stimulus waits three cycles after each command and spaces strobes four cycles apart. It changes `csN` only on clock cycles with no strobe, so every abort lands between strobes exactly as the sampled interface expects.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  localparam logic [7:0] OP_SLOW = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_DUAL = 8'h3B;
  localparam logic [7:0] OP_QUAD = 8'h6B;

  typedef enum logic [1:0] {
    LANES_1 = 2'd0,
    LANES_2 = 2'd1,
    LANES_4 = 2'd2
  } laneWidth_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DUMMY = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;

  typedef struct packed {
    logic       known;
    logic       dummy;
    laneWidth_e width;
  } rdKind_t;

  typedef struct packed {
    logic       start;
    logic       emit;
    logic       clear;
    laneWidth_e width;
  } dpCtrl_t;

  function automatic rdKind_t decodeOp(input logic [7:0] op);
    rdKind_t k;
    k = '{known: 1'b0, dummy: 1'b0, width: LANES_1};
    case (op)
      OP_SLOW: k = '{known: 1'b1, dummy: 1'b0, width: LANES_1};
      OP_FAST: k = '{known: 1'b1, dummy: 1'b1, width: LANES_1};
      OP_DUAL: k = '{known: 1'b1, dummy: 1'b1, width: LANES_2};
      OP_QUAD: k = '{known: 1'b1, dummy: 1'b1, width: LANES_4};
      default: k = '{known: 1'b0, dummy: 1'b0, width: LANES_1};
    endcase
    return k;
  endfunction

  function automatic logic [3:0] laneStep(input laneWidth_e w);
    case (w)
      LANES_2: return 4'd2;
      LANES_4: return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] laneMask(input laneWidth_e w);
    case (w)
      LANES_2: return 4'b0011;
      LANES_4: return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

endpackage

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int DUMMY_CLKS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sckFall,
  input  logic       cmdValid,
  input  logic [7:0] opcode,
  output dpCtrl_t    ctl,
  output phase_e     phase
);

  localparam int CNT_W = $clog2(DUMMY_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_CLKS - 1);

  phase_e         phaseReg;
  logic [CNT_W-1:0] dummyCnt;
  laneWidth_e     widthReg;
  rdKind_t        kind;
  logic           accept;

  always_comb begin
    kind      = decodeOp(opcode);
    accept    = cmdValid && !csN && (phaseReg == PH_IDLE) && kind.known;
    ctl.start = accept;
    ctl.emit  = (phaseReg == PH_DATA) && sckFall && !csN;
    ctl.clear = csN;
    ctl.width = widthReg;
    phase     = phaseReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseReg <= PH_IDLE;
      dummyCnt <= '0;
      widthReg <= LANES_1;
    end else if (csN) begin
      phaseReg <= PH_IDLE;
      dummyCnt <= '0;
    end else begin
      case (phaseReg)
        PH_IDLE: begin
          if (accept) begin
            widthReg <= kind.width;
            dummyCnt <= '0;
            phaseReg <= kind.dummy ? PH_DUMMY : PH_DATA;
          end
        end
        PH_DUMMY: begin
          if (sckFall) begin
            if (dummyCnt == LAST_DUMMY) begin
              phaseReg <= PH_DATA;
              dummyCnt <= '0;
            end else begin
              dummyCnt <= dummyCnt + 1'b1;
            end
          end
        end
        PH_DATA:  phaseReg <= PH_DATA;
        default:  phaseReg <= PH_IDLE;
      endcase
    end
  end

  // R2: the dummy counter never runs past the configured dummy length
  p_dummy_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phaseReg == PH_DUMMY) |-> (dummyCnt < CNT_W'(DUMMY_CLKS)));

  // R5: lane width is frozen once data streaming has begun
  p_width_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((phaseReg == PH_DATA) && ($past(phaseReg) == PH_DATA)) |-> $stable(widthReg));

endmodule

// File: rtl/flash_rd_datapath.sv
module flash_rd_datapath
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic [3:0]        laneOut,
  output logic [3:0]        laneOe
);

  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] memAddrReg;
  logic              memRdReg;
  logic              rdPend;
  logic [7:0]        bufReg;
  logic [7:0]        shReg;
  logic [3:0]        bitsLeft;
  logic [3:0]        laneReg;
  logic [3:0]        oeReg;
  logic [7:0]        curByte;
  logic [3:0]        laneNext;
  logic [3:0]        step;
  logic              byteStart;

  always_comb begin
    byteStart = (bitsLeft == 4'd0);
    curByte   = byteStart ? bufReg : shReg;
    step      = laneStep(ctl.width);
    case (ctl.width)
      LANES_2: laneNext = {2'b00, curByte[7], curByte[6]};
      LANES_4: laneNext = curByte[7:4];
      default: laneNext = {2'b00, curByte[7], 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr   <= '0;
      memAddrReg <= '0;
      memRdReg   <= 1'b0;
      rdPend     <= 1'b0;
      bufReg     <= '0;
      shReg      <= '0;
      bitsLeft   <= '0;
      laneReg    <= '0;
      oeReg      <= '0;
    end else begin
      rdPend   <= memRdReg;
      memRdReg <= 1'b0;
      if (rdPend) bufReg <= memData;
      if (ctl.clear) begin
        bitsLeft <= '0;
        oeReg    <= '0;
      end else if (ctl.start) begin
        memRdReg   <= 1'b1;
        memAddrReg <= startAddr;
        nextAddr   <= startAddr + 1'b1;
        bitsLeft   <= '0;
        oeReg      <= '0;
      end else if (ctl.emit) begin
        laneReg  <= laneNext;
        oeReg    <= laneMask(ctl.width);
        shReg    <= curByte << step;
        bitsLeft <= (byteStart ? 4'd8 : bitsLeft) - step;
        if (byteStart) begin
          memRdReg   <= 1'b1;
          memAddrReg <= nextAddr;
          nextAddr   <= nextAddr + 1'b1;
        end
      end
    end
  end

  assign memRd   = memRdReg;
  assign memAddr = memAddrReg;
  assign laneOut = laneReg;
  assign laneOe  = oeReg;

  // R3/R4/R5: only the three legal lane-enable patterns ever appear
  p_oe_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (oeReg != 4'b0000) |-> ((oeReg == 4'b0010) || (oeReg == 4'b0011) || (oeReg == 4'b1111)));

  // R6: memory requests are single-cycle pulses under legal strobe spacing
  p_fetch_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    memRdReg |=> !memRdReg);

endmodule

// File: rtl/flash_read_engine.sv
module flash_read_engine
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DUMMY_CLKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sckFall,
  input  logic              cmdValid,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe
);

  dpCtrl_t    ctl;
  phase_e     phase;
  logic [3:0] laneOe;

  flash_rd_ctrl #(
    .DUMMY_CLKS(DUMMY_CLKS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .sckFall (sckFall),
    .cmdValid(cmdValid),
    .opcode  (opcode),
    .ctl     (ctl),
    .phase   (phase)
  );

  flash_rd_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startAddr(startAddr),
    .memRd    (memRd),
    .memAddr  (memAddr),
    .memData  (memData),
    .laneOut  (ioOut),
    .laneOe   (laneOe)
  );

  assign ioOe = csN ? 4'b0000 : laneOe;

  // R5: lane values move only after a falling-edge strobe
  p_change_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sckFall) |-> $stable(ioOut));

  // R9: nothing is driven outside the data phase
  p_quiet_outside_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_DATA) |-> (ioOe == 4'b0000));

  // R8: a fresh selection never inherits enables from an aborted read
  p_fresh_select_hiz_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (ioOe == 4'b0000));

endmodule

// File: tb/sim_flash_read_engine.sv
`timescale 1ns/1ps
module sim_flash_read_engine;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rstN;
  logic          csN;
  logic          sckFall;
  logic          cmdValid;
  logic [7:0]    opcode;
  logic [AW-1:0] startAddr;
  logic          memRd;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData;
  logic [3:0]    ioOut;
  logic [3:0]    ioOe;

  int       nRun  = 0;
  int       nFail = 0;
  logic [3:0] expOe = 4'b0000;
  bit       monOn = 1'b0;
  bit       done  = 1'b0;

  always #2 clk = ~clk;

  flash_read_engine #(.ADDR_W(AW), .DUMMY_CLKS(8)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sckFall(sckFall), .cmdValid(cmdValid),
    .opcode(opcode), .startAddr(startAddr), .memRd(memRd), .memAddr(memAddr),
    .memData(memData), .ioOut(ioOut), .ioOe(ioOe)
  );

  function automatic logic [7:0] memf(input int a);
    return 8'(((a & 255) * 29) + (((a >> 8) & 255) * 7) + ((a >> 16) * 3) + 11);
  endfunction

  always_ff @(posedge clk) if (memRd) memData <= memf(int'(memAddr));

  function automatic logic [3:0] maskOf(input int w);
    return (w == 4) ? 4'b1111 : (w == 2) ? 4'b0011 : 4'b0010;
  endfunction

  function automatic logic [3:0] expLanes(input int w, input int addr, input int j);
    logic [7:0] b;
    int pos;
    b   = memf((addr + j / 8) & ((1 << AW) - 1));
    pos = j % 8;
    if (w == 4) return b[7-pos -: 4];
    if (w == 2) return {2'b00, b[7-pos], b[6-pos]};
    return {2'b00, b[7-pos], 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  // Per-clock reference comparison of lane enables (R9 / R8)
  always @(posedge clk) begin
    #1;
    if (monOn) chk(ioOe === expOe, "R9 per-clock lane enable", {4'h0, ioOe}, {4'h0, expOe});
  end

  task automatic deselect();
    @(negedge clk);
    csN   = 1'b1;
    expOe = 4'b0000;
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [7:0] op, input int addr);
    @(negedge clk);
    cmdValid  = 1'b1;
    opcode    = op;
    startAddr = AW'(addr);
    @(negedge clk);
    cmdValid  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic falls(input logic [7:0] op, input int addr, input int total, input bit accepted, input string tag);
    int d;
    int w;
    bit known;
    known = accepted;
    d = 8;
    w = 1;
    case (op)
      8'h03:   d = 0;
      8'h0B:   w = 1;
      8'h3B:   w = 2;
      8'h6B:   w = 4;
      default: known = 1'b0;
    endcase
    for (int k = 0; k < total; k++) begin
      sckFall = 1'b1;
      if (known && k >= d) expOe = maskOf(w);
      @(negedge clk);
      sckFall = 1'b0;
      if (known && k >= d) begin
        chk(ioOut === expLanes(w, addr, (k - d) * w), tag, {4'h0, ioOut},
            {4'h0, expLanes(w, addr, (k - d) * w)});
        chk(ioOe === maskOf(w), tag, {4'h0, ioOe}, {4'h0, maskOf(w)});
      end else begin
        chk(ioOe === 4'b0000, tag, {4'h0, ioOe}, 8'h00);
      end
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic doRead(input logic [7:0] op, input int addr, input int total, input string tag);
    @(negedge clk);
    csN = 1'b0;
    repeat (2) @(negedge clk);
    issue(op, addr);
    falls(op, addr, total, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sckFall = 1'b0; cmdValid = 1'b0;
    opcode = 8'h00; startAddr = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(ioOe === 4'b0000, "R9 reset enables", {4'h0, ioOe}, 8'h00);
    chk(memRd === 1'b0, "R9 reset memRd", {7'h0, memRd}, 8'h00);
    monOn = 1'b1;

    // R1, R5, R6: slow single-lane read, three bytes
    doRead(8'h03, 32'h00100, 24, "R1 R5 R6 slow read");
    deselect();
    // R2, R9: fast read with dummy phase
    doRead(8'h0B, 32'h12345, 8 + 16, "R2 R9 fast read with dummy");
    deselect();
    // R3: dual lanes
    doRead(8'h3B, 32'h00200, 8 + 12, "R3 dual read");
    deselect();
    // R4, R7: quad across the top of the array
    doRead(8'h6B, 32'h7FFFE, 8 + 8, "R4 R7 quad wrap");
    deselect();
    // R7: single-lane wrap
    doRead(8'h03, 32'h7FFFF, 16, "R7 slow wrap");
    deselect();

    // R8: abort mid-byte, enables drop in the same cycle
    doRead(8'h6B, 32'h00040, 8 + 1, "R8 quad before abort");
    doRead(8'h6B, 32'h00040, 0, "R8 unused");
    @(negedge clk);
    csN   = 1'b1;
    expOe = 4'b0000;
    #1;
    chk(ioOe === 4'b0000, "R8 immediate release", {4'h0, ioOe}, 8'h00);
    repeat (3) @(negedge clk);
    csN = 1'b0;
    repeat (2) @(negedge clk);
    falls(8'h03, 0, 6, 1'b0, "R8 no drive without new command");
    deselect();

    // R8: abort of a single-lane read after three bits
    doRead(8'h0B, 32'h00333, 8 + 3, "R8 fast before abort");
    deselect();
    chk(ioOe === 4'b0000, "R8 deselected enables", {4'h0, ioOe}, 8'h00);

    // R10: unsupported opcode
    doRead(8'h9F, 32'h00010, 16, "R10 unsupported opcode");
    deselect();

    // R10: command strobe while deselected
    issue(8'h03, 32'h00020);
    @(negedge clk);
    csN = 1'b0;
    repeat (2) @(negedge clk);
    falls(8'h03, 32'h00020, 10, 1'b0, "R10 command while deselected");
    deselect();

    // R1 again after all of the above: engine recovers fully
    doRead(8'h03, 32'h00ABC, 8, "R1 recovery read");
    deselect();

    monOn = 1'b0;
    finishRun();
  end
endmodule